// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs one add, subtract or bitwise operation on two operands and captures six condition bits describing the outcome: unsigned carry/borrow, signed overflow, sign, zero, nibble (auxiliary) carry and even parity. The operation runs at a selectable width of 8, 16 or full data width. Operand bits above the chosen width are ignored, and every flag is evaluated at that width.

The result and the six flags are registered. They load only on cycles where the update enable is high. A datapath can therefore issue operations whose flags must survive and leave the stored condition bits untouched. A branch or carry-chain consumer reads the registered flag outputs directly.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the registered result and all six flags to 0.
- R2: Width select 0 gives 8 bits and 1 gives 16 bits. Codes 2 and 3 give DATA_W bits. Operand bits above the width are ignored, and result bits above it read 0.
- R3: Operation codes: 0 A+B, 1 A+B+carry_in, 2 A-B, 3 A-B-carry_in, 4 A AND B, 5 A OR B, 6 A XOR B, 7 A XOR (NOT B). The result is truncated to the width.
- R4: For codes 0/1 the carry flag is 1 when the unsigned sum exceeds the width. For codes 2/3 it is 1 when a borrow occurs, that is, when A < B (+carry_in for code 3).
- R5: Overflow is 1 when the two's-complement result at the width cannot hold the true signed result of the add or subtract.
- R6: Sign equals the most significant result bit at the selected width.
- R7: Zero is 1 exactly when all result bits at the selected width are 0.
- R8: Auxiliary carry is 1 on a carry out of bit 3 for adds and on a borrow out of bit 3 for subtracts, including carry_in for codes 1/3.
- R9: Parity is 1 when result bits 7..0 hold an even number of ones.
- R10: Bitwise codes 4 to 7 force carry, overflow and auxiliary carry to 0.
- R11: With update enable low, the result and all flags keep their values.
- R12: carry_in has no effect for codes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Load result and flags this cycle |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| carry_in | input | 1 | Incoming carry/borrow for codes 1 and 3 |
| op_sel | input | 3 | Operation code (R3) |
| wid_sel | input | 2 | Width code (R2) |
| result | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry/borrow |
| flag_o | output | 1 | Signed overflow |
| flag_s | output | 1 | Sign |
| flag_z | output | 1 | Zero |
| flag_a | output | 1 | Auxiliary (nibble) carry |
| flag_p | output | 1 | Even parity of low byte |

## Verification
The bench builds the unit with the default DATA_W of 32. That makes all three widths reachable: 8, 16 and the full 32 bits, including the carry out of bit 31 that a 64-bit reference catches without wrap-around. Width code 3 is also driven, since it aliases the full width. Operands carry nonzero upper bits at narrow widths, which shows that the masking keeps those bits out of every flag.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_XNOR = 3'd7
  } sfu_op_e;

  typedef struct packed {
    logic c;
    logic o;
    logic s;
    logic z;
    logic a;
    logic p;
  } sfu_flags_t;

  localparam int unsigned NARROW_W0 = 8;
  localparam int unsigned NARROW_W1 = 16;

  function automatic int unsigned lane_bits(input logic [1:0] ws, input int unsigned full_w);
    int unsigned n;
    case (ws)
      2'd0:    n = NARROW_W0;
      2'd1:    n = NARROW_W1;
      default: n = full_w;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sfu_msb_pick.sv
module sfu_msb_pick #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W:0] val_i,
  input  logic [1:0]      wsel_i,
  input  logic            above_i,
  output logic            bit_o
);
  // above_i = 0 selects top bit of the lane, 1 selects the bit just above it
  always_comb begin
    case (wsel_i)
      2'd0:    bit_o = above_i ? val_i[8]      : val_i[7];
      2'd1:    bit_o = above_i ? val_i[16]     : val_i[15];
      default: bit_o = above_i ? val_i[DATA_W] : val_i[DATA_W-1];
    endcase
  end
endmodule

// File: rtl/sfu_adder.sv
module sfu_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic [1:0]        wsel_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              aux_o,
  output logic              ovf_o
);
  localparam int unsigned NPICK = 4;

  logic [DATA_W-1:0] bx;
  logic              cx;
  logic [DATA_W:0]   ext;
  logic [4:0]        nib;
  logic [DATA_W:0]   pick_src [NPICK];
  logic [NPICK-1:0]  pick_above;
  logic [NPICK-1:0]  pick_bit;

  always_comb begin
    bx  = sub_i ? (~b_i & mask_i) : (b_i & mask_i);
    cx  = sub_i ? ~cin_i : cin_i;
    ext = {1'b0, a_i} + {1'b0, bx} + {{DATA_W{1'b0}}, cx};
    nib = {1'b0, a_i[3:0]} + {1'b0, bx[3:0]} + {4'b0000, cx};
  end

  assign pick_src[0] = {1'b0, a_i};
  assign pick_src[1] = {1'b0, bx};
  assign pick_src[2] = ext;
  assign pick_src[3] = ext;
  assign pick_above  = 4'b1000;

  generate
    for (genvar g = 0; g < NPICK; g++) begin : g_pick
      sfu_msb_pick #(.DATA_W(DATA_W)) u_pick (
        .val_i  (pick_src[g]),
        .wsel_i (wsel_i),
        .above_i(pick_above[g]),
        .bit_o  (pick_bit[g])
      );
    end
  endgenerate

  // pick_bit: 0 sign A, 1 sign adjusted B, 2 sign sum, 3 carry out of lane
  assign sum_o   = ext[DATA_W-1:0] & mask_i;
  assign carry_o = pick_bit[3] ^ sub_i;
  assign aux_o   = nib[4] ^ sub_i;
  assign ovf_o   = (pick_bit[0] == pick_bit[1]) && (pick_bit[2] != pick_bit[0]);
endmodule

// File: rtl/sfu_logic.sv
module sfu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [1:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (fn_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = a_i ^ ~b_i;
    endcase
    res_o = res_o & mask_i;
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        wid_sel,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_o,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_a,
  output logic              flag_p
);
  logic [DATA_W-1:0] mask, a_m, b_m, add_res, log_res, res_n;
  logic              is_logic, add_c, add_a, add_o, sign_n;
  sfu_flags_t        flags_n, flags_q;

  always_comb begin
    for (int j = 0; j < int'(DATA_W); j++)
      mask[j] = (j < int'(lane_bits(wid_sel, DATA_W)));
    a_m = opnd_a & mask;
    b_m = opnd_b & mask;
  end

  assign is_logic = op_sel[2];

  sfu_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i    (a_m),
    .b_i    (b_m),
    .mask_i (mask),
    .sub_i  (op_sel[1]),
    .cin_i  (op_sel[0] & carry_in),
    .wsel_i (wid_sel),
    .sum_o  (add_res),
    .carry_o(add_c),
    .aux_o  (add_a),
    .ovf_o  (add_o)
  );

  sfu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_m),
    .b_i   (b_m),
    .mask_i(mask),
    .fn_i  (op_sel[1:0]),
    .res_o (log_res)
  );

  assign res_n = is_logic ? log_res : add_res;

  sfu_msb_pick #(.DATA_W(DATA_W)) u_sign (
    .val_i  ({1'b0, res_n}),
    .wsel_i (wid_sel),
    .above_i(1'b0),
    .bit_o  (sign_n)
  );

  always_comb begin
    flags_n.c = ~is_logic & add_c;
    flags_n.o = ~is_logic & add_o;
    flags_n.a = ~is_logic & add_a;
    flags_n.s = sign_n;
    flags_n.z = (res_n == '0);
    flags_n.p = ~^res_n[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      flags_q <= '0;
    end else if (upd_en) begin
      result  <= res_n;
      flags_q <= flags_n;
    end
  end

  assign flag_c = flags_q.c;
  assign flag_o = flags_q.o;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_a = flags_q.a;
  assign flag_p = flags_q.p;
endmodule

// File: rtl/sfu_chk.sv
module sfu_chk
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_en,
  input logic [2:0]        op_sel,
  input logic [1:0]        wid_sel,
  input logic [DATA_W-1:0] result,
  input logic              flag_c,
  input logic              flag_o,
  input logic              flag_s,
  input logic              flag_z,
  input logic              flag_a,
  input logic              flag_p
);
  function automatic logic msb_at(input logic [DATA_W-1:0] v, input logic [1:0] ws);
    return v[lane_bits(ws, DATA_W) - 1];
  endfunction

  function automatic logic [DATA_W-1:0] above_lane(input logic [1:0] ws);
    logic [DATA_W-1:0] m;
    for (int j = 0; j < int'(DATA_W); j++)
      m[j] = (j >= int'(lane_bits(ws, DATA_W)));
    return m;
  endfunction

  assert_upper_clear_R2: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ((result & above_lane($past(wid_sel))) == '0));

  assert_sign_msb_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flag_s == msb_at(result, $past(wid_sel))));

  assert_zero_match_R7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flag_z == (result == '0)));

  assert_parity_low_R9: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flag_p == ~^result[7:0]));

  assert_logic_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_sel[2]) |=> (!flag_c && !flag_o && !flag_a));

  assert_hold_state_R11: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(result) && $stable({flag_c, flag_o, flag_s, flag_z, flag_a, flag_p})));
endmodule

bind status_flag_unit sfu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .upd_en (upd_en),
  .op_sel (op_sel),
  .wid_sel(wid_sel),
  .result (result),
  .flag_c (flag_c),
  .flag_o (flag_o),
  .flag_s (flag_s),
  .flag_z (flag_z),
  .flag_a (flag_a),
  .flag_p (flag_p)
);

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 200000;

  logic              clk = 1'b0;
  logic              rst;
  logic              upd_en;
  logic [DATA_W-1:0] opnd_a, opnd_b, result;
  logic              carry_in;
  logic [2:0]        op_sel;
  logic [1:0]        wid_sel;
  logic              flag_c, flag_o, flag_s, flag_z, flag_a, flag_p;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  longint unsigned e_res;
  bit e_c, e_o, e_s, e_z, e_a, e_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .op_sel(op_sel), .wid_sel(wid_sel), .result(result),
    .flag_c(flag_c), .flag_o(flag_o), .flag_s(flag_s), .flag_z(flag_z),
    .flag_a(flag_a), .flag_p(flag_p)
  );

  task automatic chk(input string req, input string ctx, input longint unsigned act,
                     input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  // Behavioural reference: plain integer arithmetic at the chosen width
  task automatic model(input longint unsigned a_in, input longint unsigned b_in, input bit ci,
                       input int op, input int ws);
    int w;
    longint unsigned m, a, b, r;
    longint unsigned c;
    bit sa, sb, sr;
    w = (ws == 0) ? 8 : (ws == 1) ? 16 : DATA_W;
    m = (64'd1 << w) - 1;
    a = a_in & m;
    b = b_in & m;
    c = (op == 1 || op == 3) ? ci : 0;
    e_c = 0; e_o = 0; e_a = 0;
    sa = a[w-1];
    sb = b[w-1];
    case (op)
      0, 1: begin
        r   = (a + b + c) & m;
        e_c = ((a + b + c) > m);
        e_a = (((a & 15) + (b & 15) + c) > 15);
        sr  = r[w-1];
        e_o = (sa == sb) && (sr != sa);
      end
      2, 3: begin
        r   = (a - b - c) & m;
        e_c = (a < b + c);
        e_a = ((a & 15) < (b & 15) + c);
        sr  = r[w-1];
        e_o = (sa != sb) && (sr != sa);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      default: r = (a ^ ~b) & m;
    endcase
    e_res = r;
    e_s = r[w-1];
    e_z = (r == 0);
    e_p = ~^r[7:0];
  endtask

  task automatic compare_all(input string ctx);
    chk("R3", ctx, result, e_res);
    chk("R4", ctx, flag_c, e_c);
    chk("R5", ctx, flag_o, e_o);
    chk("R6", ctx, flag_s, e_s);
    chk("R7", ctx, flag_z, e_z);
    chk("R8", ctx, flag_a, e_a);
    chk("R9", ctx, flag_p, e_p);
  endtask

  // Drive at a falling edge, let one rising edge capture, compare at the next falling edge
  task automatic step(input longint unsigned a, input longint unsigned b, input bit ci,
                      input int op, input int ws, input bit en, input string ctx);
    opnd_a = a[DATA_W-1:0]; opnd_b = b[DATA_W-1:0]; carry_in = ci;
    op_sel = 3'(op); wid_sel = 2'(ws); upd_en = en;
    if (en) model(a, b, ci, op, ws);
    @(negedge clk);
    compare_all(ctx);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; upd_en = 1'b1; opnd_a = '1; opnd_b = '1; carry_in = 1'b1;
    op_sel = 3'd0; wid_sel = 2'd2;
    e_res = 0; e_c = 0; e_o = 0; e_s = 0; e_z = 0; e_a = 0; e_p = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset state");
    rst = 1'b0;

    // carry, nibble carry, zero at each width
    step(64'h0000_00FF, 64'h01, 0, 0, 0, 1, "R4 8-bit wrap");
    step(64'h0000_007F, 64'h01, 0, 0, 0, 1, "R5 8-bit signed overflow");
    step(64'h0000_FFFF, 64'h01, 0, 0, 1, 1, "R4 16-bit wrap");
    step(64'hFFFF_FFFF, 64'h01, 0, 0, 2, 1, "R4 32-bit wrap");
    step(64'h7FFF_FFFF, 64'h01, 0, 0, 2, 1, "R5 32-bit overflow");
    // subtraction borrow and overflow
    step(64'h00, 64'h01, 0, 2, 0, 1, "R4 R8 8-bit borrow");
    step(64'h80, 64'h01, 0, 2, 0, 1, "R5 8-bit sub overflow");
    step(64'h10, 64'h01, 0, 2, 0, 1, "R8 nibble borrow");
    step(64'h1234, 64'h1234, 0, 2, 1, 1, "R7 16-bit zero");
    // carry-in ops
    step(64'h0F, 64'h00, 1, 1, 0, 1, "R8 carry_in into nibble");
    step(64'hFF, 64'hFF, 1, 1, 0, 1, "R4 add with carry_in");
    step(64'h05, 64'h05, 1, 3, 0, 1, "R4 sub with borrow_in");
    // carry_in ignored for plain add/sub
    step(64'h0F, 64'h00, 1, 0, 0, 1, "R12 add ignores carry_in");
    step(64'h05, 64'h05, 1, 2, 0, 1, "R12 sub ignores carry_in");
    // upper bits ignored at narrow widths
    step(64'hABCD_12F0, 64'h5555_0010, 0, 0, 0, 1, "R2 upper bits ignored 8");
    step(64'hFFFF_8000, 64'h0000_8000, 0, 0, 1, 1, "R2 upper bits ignored 16");
    step(64'h8000_0000, 64'h8000_0000, 0, 0, 3, 1, "R2 code 3 full width");
    // bitwise ops
    step(64'hF0F0_F0FF, 64'h0F0F_0F0F, 1, 4, 2, 1, "R10 and");
    step(64'hFFFF_FF00, 64'h0000_00FF, 1, 5, 0, 1, "R10 or");
    step(64'h1234_5678, 64'h1234_5678, 1, 6, 2, 1, "R10 xor zero");
    step(64'h0000_00AA, 64'h0000_0055, 1, 7, 0, 1, "R10 xnor");
    // hold when update enable low
    step(64'hFF, 64'h01, 0, 0, 0, 1, "R3 before hold");
    step(64'h00, 64'h01, 0, 2, 2, 0, "R11 hold sub");
    step(64'h12, 64'h34, 1, 7, 1, 0, "R11 hold xnor");

    for (int i = 0; i < 600; i++) begin
      longint unsigned ra, rb;
      ra = {32'd0, $urandom};
      rb = {32'd0, $urandom};
      if (i % 5 == 0) rb = ra;
      step(ra, rb, 1'($urandom), int'($urandom % 8), int'($urandom % 4),
           ($urandom % 6) != 0, "R3 random");
    end

    finish_run();
  end
endmodule